// File: doc/BRIEF.md
# Duty-Corrected Programmable Clock Divider

This block divides one input clock by any integer from 1 up to 2^DIV_W. The programmed value plus one is the ratio. Even ratios give an output that is high for exactly half of its period. Ratio 1 hands the input clock straight to the output, so the output keeps the input's duty cycle. Odd ratios above 1 keep the output high for (N-1)/2 whole input periods and then for the high part of one more input period. A register clocked on the falling input edge supplies that extra part, which brings the duty cycle close to one half.

A polarity select inverts the output. When the output is not inverted, the falling edge is the one that moves. When it is inverted, the rising edge moves. A new ratio and the enable are taken in only at the end of an output period, so no pulse is cut short or stretched. A synchronous reset clears the count and drives the output to its inactive level.

The block carries no data stream. All of its pins are plain control and clock signals, so it has no valid/ready handshake and no back-pressure.

Top module: `clkdiv_dc`

## Requirements
- R1: The output period is N input periods, with N = div_val + 1. For example, div_val = 3 gives divide-by-4.
- R2: For an even N, the output is high for exactly N/2 input periods.
- R3: When N = 1, the output follows the input clock (inverted when invert = 1), so the output duty cycle equals the input duty cycle.
- R4: For an odd N > 1, the output is high for (N-1)/2 input periods plus one input high time. This gives a duty cycle of (N-1+2X)/(2N). For example, N = 5 with a 20% input gives 44%.
- R5: With invert = 0 and an odd N > 1, the output rises on an input rising edge and falls on an input falling edge. The falling edge is the one that is moved.
- R6: With invert = 1, the output is the complement of the non-inverted waveform. For an odd N > 1, it rises on an input falling edge (the moved edge) and falls on an input rising edge.
- R7: A change to div_val takes effect only at the end of the current output period. The pulse in progress and the rest of that period keep the old ratio.
- R8: A rising input edge that samples rst = 1 clears the counter and puts the output at its inactive level: 0 when invert = 0, 1 when invert = 1.
- R9: en is sampled only at an output period boundary. After the boundary that samples en = 0, the output stays at its inactive level. A period that is already running completes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable, sampled at period boundaries |
| invert | input | 1 | 1 selects the inverted output polarity |
| div_val | input | DIV_W | Divide ratio minus one |
| clk_out | output | 1 | Divided clock |

## Verification
The bench builds the block with the default DIV_W = 30. It programs small ratios from 1 to 10 so that every period is measured in full. It sets the input clock's high time to 1, 2, 2.5 and 4 ns of the 5 ns period, which makes the odd-ratio correction show up directly as a shift in the edge time. These settings cover bypass, both parities, both polarities, and changes of ratio, enable and reset in the middle of a period.

// File: rtl/clkdiv_dc_pkg.sv
package clkdiv_dc_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_BYPASS = 2'd1,
    MODE_EVEN   = 2'd2,
    MODE_ODD    = 2'd3
  } div_mode_e;

  function automatic div_mode_e classify(input logic run, input logic is_one,
                                         input logic is_odd);
    if (!run)        return MODE_IDLE;
    else if (is_one) return MODE_BYPASS;
    else if (is_odd) return MODE_ODD;
    else             return MODE_EVEN;
  endfunction

endpackage

// File: rtl/clkdiv_dc_seq.sv
module clkdiv_dc_seq
  import clkdiv_dc_pkg::*;
#(
  parameter int DIV_W = 30,
  localparam int CW = DIV_W + 1
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div_val,
  output div_mode_e        mode_q,
  output logic [CW-1:0]    cnt_q,
  output logic [CW-1:0]    ratio_q,
  output logic             hi_q
);

  logic [CW-1:0] ratio_next;
  logic [CW-1:0] cnt_inc;
  logic [CW-1:0] half_ratio;
  logic          at_end;

  assign ratio_next = {1'b0, div_val} + {{(CW-1){1'b0}}, 1'b1};
  assign cnt_inc    = cnt_q + {{(CW-1){1'b0}}, 1'b1};
  assign half_ratio = ratio_q >> 1;
  assign at_end     = (mode_q == MODE_IDLE) || (cnt_inc == ratio_q);

  always_ff @(posedge clk_in) begin
    if (rst) begin
      mode_q  <= MODE_IDLE;
      cnt_q   <= '0;
      ratio_q <= {{(CW-1){1'b0}}, 1'b1};
      hi_q    <= 1'b0;
    end else if (at_end) begin
      cnt_q   <= '0;
      ratio_q <= ratio_next;
      mode_q  <= classify(en, ratio_next == {{(CW-1){1'b0}}, 1'b1}, ratio_next[0]);
      hi_q    <= en;
    end else begin
      cnt_q   <= cnt_inc;
      hi_q    <= (cnt_inc < half_ratio);
    end
  end

endmodule

// File: rtl/clkdiv_dc_ext.sv
module clkdiv_dc_ext
  import clkdiv_dc_pkg::*;
(
  input  logic      clk_in,
  input  div_mode_e mode_q,
  input  logic      hi_q,
  output logic      ext_q
);

  always_ff @(negedge clk_in) begin
    ext_q <= hi_q && (mode_q == MODE_ODD);
  end

endmodule

// File: rtl/clkdiv_dc_out.sv
module clkdiv_dc_out
  import clkdiv_dc_pkg::*;
(
  input  logic      clk_in,
  input  div_mode_e mode_q,
  input  logic      hi_q,
  input  logic      ext_q,
  input  logic      invert,
  output logic      clk_out
);

  logic base;

  always_comb begin
    unique case (mode_q)
      MODE_BYPASS: base = clk_in;
      MODE_EVEN:   base = hi_q;
      MODE_ODD:    base = hi_q | ext_q;
      default:     base = 1'b0;
    endcase
    clk_out = base ^ invert;
  end

endmodule

// File: rtl/clkdiv_dc.sv
module clkdiv_dc
  import clkdiv_dc_pkg::*;
#(
  parameter int DIV_W = 30
) (
  input  logic             clk_in,
  input  logic             rst,
  input  logic             en,
  input  logic             invert,
  input  logic [DIV_W-1:0] div_val,
  output logic             clk_out
);

  localparam int CW = DIV_W + 1;

  div_mode_e     mode_w;
  logic [CW-1:0] cnt_w;
  logic [CW-1:0] ratio_w;
  logic          hi_w;
  logic          ext_w;

  clkdiv_dc_seq #(.DIV_W(DIV_W)) u_seq (
    .clk_in (clk_in),
    .rst    (rst),
    .en     (en),
    .div_val(div_val),
    .mode_q (mode_w),
    .cnt_q  (cnt_w),
    .ratio_q(ratio_w),
    .hi_q   (hi_w)
  );

  clkdiv_dc_ext u_ext (
    .clk_in(clk_in),
    .mode_q(mode_w),
    .hi_q  (hi_w),
    .ext_q (ext_w)
  );

  clkdiv_dc_out u_out (
    .clk_in (clk_in),
    .mode_q (mode_w),
    .hi_q   (hi_w),
    .ext_q  (ext_w),
    .invert (invert),
    .clk_out(clk_out)
  );

endmodule

// File: rtl/clkdiv_dc_checker.sv
module clkdiv_dc_checker
  import clkdiv_dc_pkg::*;
#(
  parameter int DIV_W = 30,
  localparam int CW = DIV_W + 1
) (
  input logic          clk_in,
  input logic          rst,
  input div_mode_e     mode_w,
  input logic [CW-1:0] cnt_w,
  input logic [CW-1:0] ratio_w,
  input logic          ext_w
);

  a_r8_reset_clears: assert property (@(posedge clk_in)
    rst |=> (mode_w == MODE_IDLE && cnt_w == '0));

  a_r1_count_steps: assert property (@(posedge clk_in) disable iff (rst)
    (mode_w != MODE_IDLE && cnt_w + 1'b1 != ratio_w) |=> (cnt_w == $past(cnt_w) + 1'b1));

  a_r1_count_in_range: assert property (@(posedge clk_in) disable iff (rst)
    (mode_w != MODE_IDLE) |-> (cnt_w < ratio_w));

  a_r7_ratio_held: assert property (@(posedge clk_in) disable iff (rst)
    (mode_w != MODE_IDLE && cnt_w + 1'b1 != ratio_w) |=> $stable(ratio_w));

  a_r2_no_extension_even: assert property (@(posedge clk_in) disable iff (rst)
    (mode_w == MODE_EVEN) |-> !ext_w);

endmodule

bind clkdiv_dc clkdiv_dc_checker #(.DIV_W(DIV_W)) u_chk (
  .clk_in (clk_in),
  .rst    (rst),
  .mode_w (mode_w),
  .cnt_w  (cnt_w),
  .ratio_w(ratio_w),
  .ext_w  (ext_w)
);

// File: tb/clkdiv_dc_bench.sv
`timescale 1ns/1ps
module clkdiv_dc_bench;

  localparam int DIV_W = 30;
  localparam real TCK = 5.0;
  localparam int NV = 10;

  typedef struct packed {
    logic [7:0] div;
    logic       inv;
    logic [7:0] hi10;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'd3, 1'b0, 8'd25},
    '{8'd1, 1'b0, 8'd25},
    '{8'd4, 1'b0, 8'd10},
    '{8'd4, 1'b1, 8'd10},
    '{8'd2, 1'b0, 8'd25},
    '{8'd0, 1'b0, 8'd10},
    '{8'd0, 1'b1, 8'd10},
    '{8'd6, 1'b0, 8'd40},
    '{8'd9, 1'b1, 8'd25},
    '{8'd2, 1'b1, 8'd20}
  };

  logic clk_in = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic invert = 1'b0;
  logic [DIV_W-1:0] div_val = '0;
  logic clk_out;
  real  hi_ns = 2.5;

  int n_checks = 0;
  int n_fails = 0;

  clkdiv_dc #(.DIV_W(DIV_W)) u_clkdiv_dc (
    .clk_in (clk_in),
    .rst    (rst),
    .en     (en),
    .invert (invert),
    .div_val(div_val),
    .clk_out(clk_out)
  );

  initial begin
    forever begin
      #(TCK - hi_ns) clk_in = 1'b1;
      #(hi_ns) clk_in = 1'b0;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk_in);
    n_fails++;
    $display("FAIL watchdog (R1..R9 run): got hang, expected completion");
    summary();
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: got %0.2f expected %0.2f", req, what, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < 0.05) && (b - a < 0.05);
  endfunction

  task automatic measure(output real hi, output real per,
                         output logic ck_at_rise, output logic ck_at_fall);
    real t0, t1, t2;
    @(posedge clk_out); t0 = $realtime; #0.1 ck_at_rise = clk_in;
    @(negedge clk_out); t1 = $realtime; #0.1 ck_at_fall = clk_in;
    @(posedge clk_out); t2 = $realtime;
    hi  = t1 - t0;
    per = t2 - t0;
  endtask

  initial begin
    real hi, per, base_hi, exp_hi, exp_per, t0, t1, t2;
    logic cr, cf;
    bit ok;
    int n;

    // R8: reset state, both polarities
    repeat (4) @(posedge clk_in);
    #1 chk(clk_out == 1'b0, "R8", "reset level inv=0", clk_out, 0);
    invert = 1'b1;
    #0.5 chk(clk_out == 1'b1, "R8", "reset level inv=1", clk_out, 1);
    invert = 1'b0;
    @(posedge clk_in); #1 rst = 1'b0; en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      div_val = DIV_W'(VECS[i].div);
      invert  = VECS[i].inv;
      hi_ns   = real'(VECS[i].hi10) / 10.0;
      n = int'(VECS[i].div) + 1;
      repeat (3 * n + 6) @(posedge clk_in);
      #1 measure(hi, per, cr, cf);
      exp_per = TCK * n;
      if (n == 1)          base_hi = hi_ns;
      else if (n % 2 == 0) base_hi = TCK * n / 2.0;
      else                 base_hi = TCK * ((n - 1) / 2) + hi_ns;
      exp_hi = VECS[i].inv ? exp_per - base_hi : base_hi;
      chk(near(per, exp_per), "R1", "period", per, exp_per);
      if (n == 1)          chk(near(hi, exp_hi), "R3", "bypass high time", hi, exp_hi);
      else if (n % 2 == 0) chk(near(hi, exp_hi), "R2", "even high time", hi, exp_hi);
      else                 chk(near(hi, exp_hi), "R4", "odd high time", hi, exp_hi);
      if (n > 1 && n % 2 == 1) begin
        if (!VECS[i].inv) begin
          chk(cr == 1'b1, "R5", "rise on input rise", cr, 1);
          chk(cf == 1'b0, "R5", "fall on input fall", cf, 0);
        end else begin
          chk(cr == 1'b0, "R6", "rise on input fall", cr, 0);
          chk(cf == 1'b1, "R6", "fall on input rise", cf, 1);
        end
      end
      #1;
    end

    // R7: ratio change mid-period
    hi_ns = 2.5; invert = 1'b0; div_val = DIV_W'(7);
    repeat (30) @(posedge clk_in);
    @(posedge clk_out); t0 = $realtime;
    #7 div_val = DIV_W'(1);
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    chk(near(t1 - t0, 20.0), "R7", "old high time kept", t1 - t0, 20.0);
    chk(near(t2 - t0, 40.0), "R7", "old period kept", t2 - t0, 40.0);
    measure(hi, per, cr, cf);
    chk(near(per, 10.0), "R7", "new period", per, 10.0);

    // R9: disable completes running pulse, then stays inactive
    div_val = DIV_W'(7);
    repeat (30) @(posedge clk_in);
    @(posedge clk_out); t0 = $realtime;
    #1 en = 1'b0;
    @(negedge clk_out); t1 = $realtime;
    chk(near(t1 - t0, 20.0), "R9", "pulse completes", t1 - t0, 20.0);
    ok = 1'b1;
    repeat (40) begin @(posedge clk_in); #1 if (clk_out !== 1'b0) ok = 1'b0; end
    chk(ok, "R9", "idle level inv=0", clk_out, 0);
    invert = 1'b1;
    ok = 1'b1;
    repeat (20) begin @(posedge clk_in); #1 if (clk_out !== 1'b1) ok = 1'b0; end
    chk(ok, "R9", "idle level inv=1", clk_out, 1);
    invert = 1'b0; en = 1'b1;
    repeat (30) @(posedge clk_in);
    measure(hi, per, cr, cf);
    chk(near(per, 40.0), "R9", "restart period", per, 40.0);

    // R8: reset in mid-run forces inactive level at the next edge
    div_val = DIV_W'(3);
    repeat (20) @(posedge clk_in);
    @(posedge clk_out); #1 rst = 1'b1;
    @(posedge clk_in); #1 chk(clk_out == 1'b0, "R8", "mid-run reset level", clk_out, 0);
    ok = 1'b1;
    repeat (10) begin @(posedge clk_in); #1 if (clk_out !== 1'b0) ok = 1'b0; end
    chk(ok, "R8", "held in reset", clk_out, 0);
    rst = 1'b0;
    repeat (20) @(posedge clk_in);
    measure(hi, per, cr, cf);
    chk(near(per, 20.0), "R8", "runs after reset", per, 20.0);

    summary();
    $finish;
  end

endmodule